// File: doc/BRIEF.md
# Recursive Non-Zero Maximum Window Unit

This block is the per-pass engine of an iterative connected-component labeller. Label words enter one per accepted cycle, column by column, for an N by N image; inside each column the rows arrive top to bottom. Every non-zero pixel is replaced by the largest label found among itself, the result just above it in the same column, and the three results at rows r-1, r and r+1 of the previous column. A zero pixel stays zero. The window therefore gives 8-connectivity.

Every result is pushed back into the window history in place of the source pixel. Later window positions in the same pass see the updated labels, so a label can travel the whole length of a column, and onward, in one pass. A single column-length history register plus one delay stage holds all the context the window needs. Row and column counters mask neighbours that fall outside the image. In particular, the bottom of one column never feeds the top of the next.

A sticky flag records whether any output pixel differed from its input during the current pass. An outer sequencer, which is not part of this block, repeats passes and reverses the scan order between them. It stops when the flag stays clear.

Top module: `ccl_window_unit`

## Requirements
- R1: An accepted input pixel of value 0 produces an output of 0, whatever its neighbours hold.
- R2: A non-zero pixel at row r>0 is raised to at least the result produced for row r-1 of the same column.
- R3: A non-zero pixel in column c>0 is raised to the largest of the results at rows r-1, r and r+1 of column c-1, where those rows exist (8-connectivity).
- R4: The window reads results, not source pixels. A column entering as 9,1,1,1 leaves as 9,9,9,9 in one pass.
- R5: The row-0 pixel of a column never sees the row N-1 result of the previous column as its upper neighbour.
- R6: Neighbours outside the image count as 0. This covers every previous-column neighbour in column 0, the upper neighbours of row 0, and the lower-diagonal neighbour of row N-1.
- R7: Every accepted pixel produces exactly one output, with outValid high on the clock edge after acceptance. Cycles with inValid low produce no output.
- R8: passChanged clears on the pixel accepted with frameStart high. It then rises, and stays high for the rest of the pass, as soon as any output differs from its input. It is final once the last output of the frame is visible.
- R9: A frame in which no output differs from its input (for example all zeros, or a uniform label) leaves passChanged low.
- R10: Idle cycles between pixels do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Pixel on inLabel is accepted this cycle |
| frameStart | input | 1 | Marks the first pixel (row 0, column 0) of a pass |
| inLabel | input | W | Incoming label word |
| outValid | output | 1 | outLabel carries a result |
| outLabel | output | W | Windowed result for the pixel accepted one cycle earlier |
| passChanged | output | 1 | Sticky flag: some output of this pass differed from its input |

## Verification
The hardest case to reach from the ports is the point where a stale history value lines up with a window tap that must be masked. One case is row 0 of a column, where the immediately preceding result is the previous column's bottom row. The other is row N-1, where the lower-diagonal tap holds the current column's row 0. The stimulus plants a large label at exactly that source position and a small label at the pixel under test, with every genuine neighbour left at zero. Any leak then shows up as a wrong output. A bench-side model of the window recomputes whole frames, including pseudo-random frames sent both back to back and with idle gaps, to compare every output word and the final flag.

// File: rtl/ccl_pkg.sv
package ccl_pkg;
  // Strobes handed from the position control to the window datapath.
  typedef struct packed {
    logic advance;    // a pixel is accepted this cycle
    logic newPass;    // accepted pixel opens a new pass
    logic topRow;     // pixel sits in row 0
    logic bottomRow;  // pixel sits in row N-1
    logic firstCol;   // pixel sits in column 0
  } winCtl_t;
endpackage

// File: rtl/ccl_win_ctrl.sv
module ccl_win_ctrl
  import ccl_pkg::*;
#(
  parameter int N = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    frameStart,
  output winCtl_t ctl
);
  localparam int RW = (N > 2) ? $clog2(N) : 1;
  localparam logic [RW-1:0] LAST = RW'(N - 1);

  logic [RW-1:0] rowCnt, colCnt;
  logic [RW-1:0] effRow, effCol;

  // frameStart forces the position back to the image origin
  assign effRow = frameStart ? '0 : rowCnt;
  assign effCol = frameStart ? '0 : colCnt;

  always_comb begin
    ctl.advance   = inValid;
    ctl.newPass   = inValid & frameStart;
    ctl.topRow    = (effRow == '0);
    ctl.bottomRow = (effRow == LAST);
    ctl.firstCol  = (effCol == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowCnt <= '0;
      colCnt <= '0;
    end else if (inValid) begin
      if (effRow == LAST) begin
        rowCnt <= '0;
        colCnt <= (effCol == LAST) ? '0 : effCol + 1'b1;
      end else begin
        rowCnt <= effRow + 1'b1;
        colCnt <= effCol;
      end
    end
  end
endmodule

// File: rtl/ccl_win_datapath.sv
module ccl_win_datapath
  import ccl_pkg::*;
#(
  parameter int N = 16,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  winCtl_t      ctl,
  input  logic [W-1:0] inLabel,
  output logic [W-1:0] outLabel,
  output logic         outValid,
  output logic         passChanged
);
  // hist[0] is the newest result; hist[N] is N+1 results back
  localparam int DEPTH = N + 1;

  logic [W-1:0] hist [DEPTH];
  logic [W-1:0] above, diagUp, left, diagDn;
  logic [W-1:0] mA, mB, mC, mD, result;
  logic         differs;

  function automatic logic [W-1:0] max2(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  // Taps: (r-1,c) one back, (r+1,c-1) N-1 back, (r,c-1) N back, (r-1,c-1) N+1 back
  assign above  = ctl.topRow                      ? '0 : hist[0];
  assign diagDn = (ctl.firstCol | ctl.bottomRow)  ? '0 : hist[N-2];
  assign left   = ctl.firstCol                    ? '0 : hist[N-1];
  assign diagUp = (ctl.firstCol | ctl.topRow)     ? '0 : hist[N];

  // Four two-input maximum stages
  assign mA = max2(inLabel, above);
  assign mB = max2(diagUp, left);
  assign mC = max2(mA, mB);
  assign mD = max2(mC, diagDn);

  assign result  = (inLabel == '0) ? '0 : mD;
  assign differs = (result != inLabel);

  // Results, not source pixels, enter the history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hist[0] <= '0;
    else if (ctl.advance) hist[0] <= result;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_hist
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) hist[i] <= '0;
      else if (ctl.advance) hist[i] <= hist[i-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLabel    <= '0;
      outValid    <= 1'b0;
      passChanged <= 1'b0;
    end else begin
      outValid <= ctl.advance;
      if (ctl.advance) outLabel <= result;
      if (ctl.newPass) passChanged <= differs;
      else if (ctl.advance && differs) passChanged <= 1'b1;
    end
  end
endmodule

// File: rtl/ccl_window_unit.sv
module ccl_window_unit
  import ccl_pkg::*;
#(
  parameter int N = 16,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         frameStart,
  input  logic [W-1:0] inLabel,
  output logic         outValid,
  output logic [W-1:0] outLabel,
  output logic         passChanged
);
  winCtl_t ctl;

  ccl_win_ctrl #(.N(N)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .frameStart (frameStart),
    .ctl        (ctl)
  );

  ccl_win_datapath #(.N(N), .W(W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .inLabel     (inLabel),
    .outLabel    (outLabel),
    .outValid    (outValid),
    .passChanged (passChanged)
  );
endmodule

// File: rtl/ccl_win_checker.sv
module ccl_win_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic         frameStart,
  input logic [W-1:0] inLabel,
  input logic         outValid,
  input logic [W-1:0] outLabel,
  input logic         passChanged
);
  // R1
  zero_in_zero_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inLabel == '0) |=> (outValid && outLabel == '0));

  // R2
  never_below_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inLabel != '0) |=> (outLabel >= $past(inLabel)));

  // R6
  origin_passthrough_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && frameStart) |=> (outLabel == $past(inLabel)));

  // R7
  one_out_per_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R7
  no_out_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R8
  change_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLabel != $past(inLabel)) |-> passChanged);

  // R8
  flag_clears_only_at_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(passChanged) |-> $past(inValid && frameStart));
endmodule

bind ccl_window_unit ccl_win_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .frameStart  (frameStart),
  .inLabel     (inLabel),
  .outValid    (outValid),
  .outLabel    (outLabel),
  .passChanged (passChanged)
);

// File: tb/ccl_window_unit_bench.sv
module ccl_window_unit_bench;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int NP = N * N;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         frameStart = 1'b0;
  logic [W-1:0] inLabel = '0;
  logic         outValid;
  logic [W-1:0] outLabel;
  logic         passChanged;

  int vectors = 0;
  int fails = 0;
  int img [NP];
  int expv [NP];
  bit expChanged;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  ccl_window_unit #(.N(N), .W(W)) u_ccl_window_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .frameStart(frameStart),
    .inLabel(inLabel), .outValid(outValid), .outLabel(outLabel),
    .passChanged(passChanged)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Window model built from the requirements; index = col*N + row
  task automatic model();
    int m;
    expChanged = 0;
    for (int c = 0; c < N; c++)
      for (int r = 0; r < N; r++) begin
        int k = c * N + r;
        if (img[k] == 0) m = 0;
        else begin
          m = img[k];
          if (r > 0 && expv[k-1] > m) m = expv[k-1];
          if (c > 0 && expv[k-N] > m) m = expv[k-N];
          if (c > 0 && r > 0 && expv[k-N-1] > m) m = expv[k-N-1];
          if (c > 0 && r < N-1 && expv[k-N+1] > m) m = expv[k-N+1];
        end
        expv[k] = m;
        if (m != img[k]) expChanged = 1;
      end
  endtask

  task automatic checkPix(input string req, input int k);
    chk(outValid === 1'b1, {req, " outValid"}, int'(outValid), 1);
    chk(outLabel == W'(expv[k]), req, int'(outLabel), expv[k]);
  endtask

  task automatic runFrame(input string req, input int gap);
    int pend = -1;
    model();
    for (int k = 0; k < NP; k++) begin
      @(negedge clk);
      if (pend >= 0) checkPix(req, pend);
      inValid = 1'b1; frameStart = (k == 0); inLabel = W'(img[k]);
      pend = k;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        if (pend >= 0) begin
          checkPix(req, pend);
          pend = -1; inValid = 1'b0; frameStart = 1'b0;
        end else chk(outValid == 1'b0, "R7 idle", int'(outValid), 0);
      end
    end
    @(negedge clk);
    if (pend >= 0) checkPix(req, pend);
    inValid = 1'b0; frameStart = 1'b0;
    chk(passChanged == expChanged, {req, " R8 flag"}, int'(passChanged), int'(expChanged));
  endtask

  task automatic clearImg();
    for (int k = 0; k < NP; k++) img[k] = 0;
  endtask

  task automatic fillRandom();
    for (int k = 0; k < NP; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      img[k] = lfsr[0] ? int'(lfsr[8:4]) + 1 : 0;
    end
  endtask

  task automatic testReset();
    chk(outValid == 1'b0, "R7 reset outValid", int'(outValid), 0);
    chk(passChanged == 1'b0, "R8 reset flag", int'(passChanged), 0);
    chk(outLabel == '0, "R1 reset outLabel", int'(outLabel), 0);
  endtask

  task automatic testAllZero();
    clearImg();
    runFrame("R1 R9 zero frame", 0);
    chk(passChanged == 1'b0, "R9 zero frame flag", int'(passChanged), 0);
  endtask

  task automatic testVertical();
    clearImg();
    img[0] = 9; img[1] = 1; img[2] = 1; img[3] = 1;
    runFrame("R2 R4 vertical", 0);
    chk(expv[3] == 9, "R4 model column end", expv[3], 9);
  endtask

  task automatic testColumnWrap();
    clearImg();
    img[3] = 9; img[4] = 1;   // bottom of col 0, top of col 1
    runFrame("R5 column wrap", 0);
    chk(expv[4] == 1, "R5 model top row", expv[4], 1);
  endtask

  task automatic testBottomDiag();
    clearImg();
    img[4] = 7; img[7] = 2;   // col 1 row 0 large, row 3 small
    runFrame("R6 bottom diagonal", 1);
  endtask

  task automatic testDiagonal();
    clearImg();
    img[1] = 8; img[4] = 3; img[6] = 3;   // (1,0) feeds (0,1) and (2,1)
    runFrame("R3 diagonal", 0);
  endtask

  task automatic testUniform();
    for (int k = 0; k < NP; k++) img[k] = 5;
    runFrame("R9 uniform", 0);
    chk(passChanged == 1'b0, "R9 uniform flag", int'(passChanged), 0);
  endtask

  task automatic testRandom();
    for (int t = 0; t < 4; t++) begin
      fillRandom();
      runFrame("R3 R4 random back-to-back", 0);
      runFrame("R10 random with gaps", 2);
    end
  endtask

  task automatic testFlagClear();
    clearImg();
    img[0] = 6; img[1] = 2;
    runFrame("R8 changing pass", 0);
    clearImg();
    runFrame("R8 clear on new pass", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testAllZero();
    testVertical();
    testColumnWrap();
    testBottomDiag();
    testDiagonal();
    testUniform();
    testRandom();
    testFlagClear();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule